// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block sequences the vertical timing of one display pipe, one scanline at a time, and allows the frame length to float. It counts line-tick strobes within each frame and decides on which tick the vertical blank ends and the next frame begins. With variable refresh off, every frame has a fixed length and the shadowed timing registers take their new values at the start of vertical blank. With variable refresh on, a frame ends somewhere between an earliest exit line and a hard deadline. Software picks the point in that window by posting a push request.

Software writes the line counts as the count minus one, sets the push-enable bit, and then sets the control enable bit in a final write. The controller reports through a live-enable output whether frames are currently being timed in variable mode. That output changes only at a frame boundary, so turning the enable off lets the current frame complete first.

Top module: `vrr_timing_ctrl`

## Requirements
- R1: The register file has five registers: address 0 is the minimum total, 1 is the maximum total and 2 is the flip line, each holding the line count minus one in bits [15:0]. Address 3 is control: bit 0 is enable, bit 1 is flip-line enable, bit 2 is ignore-max-shift, and bits [15:8] are the guardband in lines. Address 4 is push: bit 0 is push enable and bit 1 is push send. Every register reads back what was written. The exception is push send, which reads as described in R9.
- R2: With live-enable low, a frame lasts exactly max+1 line ticks. regLatch pulses on the tick that brings the line counter to the vblank start line, which is max+1 − max(guardband,1), floored at 0.
- R3: vblank is high from the vblank start line until the end of the frame, and it is low on line 0 of a new frame whenever the vblank start line is nonzero.
- R4: On the tick that ends a frame, the line counter returns to 0 and frameStart is high for exactly the one clock after that tick.
- R5: With live-enable high and no push pending, the frame is forced to end on its max+1-th tick. In variable mode regLatch pulses only together with frameStart.
- R6: With live-enable high, a push that is already pending early in the frame ends the frame at the earliest exit line. With flip-line enable set, that line is flip+1.
- R7: A push posted after the earliest exit line ends the frame on the next line tick.
- R8: The earliest exit is never before one line past the minimum total: with flip-line enable set it is max(flip+1, min+2) lines. With flip-line enable clear it is min+1 lines.
- R9: Push send is set only by a write to the push register whose data has both bit 0 and bit 1 set; with bit 0 clear the send is dropped and reads back 0. It reads back 1 until a variable-mode frame end consumes it. Fixed-mode frames neither honour it nor clear it.
- R10: liveEn copies the control enable bit only on a frame-ending tick. After enable is set, the current frame finishes with fixed timing. After enable is cleared, the current frame finishes with variable timing.
- R11: The minimum, maximum, flip-line and control fields drive the timing only after a regLatch. A maximum total written in the middle of a frame does not change the length of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-clock strobe per scanline |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| vblank | output | 1 | Vertical blank level |
| frameStart | output | 1 | One-clock pulse after a frame-ending tick |
| regLatch | output | 1 | One-clock pulse when shadowed timing registers load |
| liveEn | output | 1 | Variable refresh currently in effect |

## Verification
The bench compares a push that is already pending before the flip line with a push posted after the flip line. A design that confused the two would either end the frame at once or wait for the deadline. It programs a flip line below the minimum total, where a missing clamp would give a frame that is too short. It also clears flip-line enable and checks that the earliest exit falls back to the minimum total. It toggles the enable bit in both directions, where a design that switched mode in the middle of a frame would give a wrong frame length or a wrong latch position. It also checks that fixed-mode frames leave a pending push untouched and that a push sent without its enable bit is dropped.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MIN  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MAX  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLIP = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PUSH = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_FLIP_BIT = 1;
  localparam int CTRL_IGN_BIT  = 2;
  localparam int CTRL_GB_LSB   = 8;
  localparam int PUSH_EN_BIT   = 0;
  localparam int PUSH_SEND_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic latch;
    logic consume;
  } vrrStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic atDeadline;
    logic atEarliest;
    logic pushPending;
    logic hitVbsStep;
    logic geVbsStep;
    logic vbsZero;
    logic ctrlEnable;
  } vrrFlags_t;
endpackage

// File: rtl/vrr_datapath.sv
module vrr_datapath
  import vrr_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int GB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LINE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LINE_W-1:0] rdData,
  input  vrrStrobe_t        strobe,
  output vrrFlags_t         flags,
  output logic [LINE_W-1:0] lineCnt,
  output logic [LINE_W-1:0] actMax,
  output logic              pushSend
);
  localparam int EXT_W = LINE_W + 1;

  logic [LINE_W-1:0] progMin, progMax, progFlip;
  logic [GB_W-1:0]   progGuard;
  logic              progEn, progFlipEn, progIgn, pushEn;

  logic [LINE_W-1:0] actMin, actFlip;
  logic [GB_W-1:0]   actGuard;
  logic              actFlipEn;

  logic [EXT_W-1:0]  lineNext, totalExt, guardEff, vbStart, minPlusOne, earliestReg;
  logic              unusedBits;

  assign unusedBits = ^wrData[CTRL_GB_LSB-1:CTRL_IGN_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progMin    <= '0;
      progMax    <= '0;
      progFlip   <= '0;
      progGuard  <= '0;
      progEn     <= 1'b0;
      progFlipEn <= 1'b0;
      progIgn    <= 1'b0;
      pushEn     <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_MIN:  progMin  <= wrData;
        ADDR_MAX:  progMax  <= wrData;
        ADDR_FLIP: progFlip <= wrData;
        ADDR_CTRL: begin
          progEn     <= wrData[CTRL_EN_BIT];
          progFlipEn <= wrData[CTRL_FLIP_BIT];
          progIgn    <= wrData[CTRL_IGN_BIT];
          progGuard  <= wrData[CTRL_GB_LSB +: GB_W];
        end
        ADDR_PUSH: pushEn <= wrData[PUSH_EN_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushSend <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_PUSH) begin
      pushSend <= wrData[PUSH_EN_BIT] & wrData[PUSH_SEND_BIT];
    end else if (strobe.consume) begin
      pushSend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMin    <= '0;
      actMax    <= '0;
      actFlip   <= '0;
      actGuard  <= '0;
      actFlipEn <= 1'b0;
    end else if (strobe.latch) begin
      actMin    <= progMin;
      actMax    <= progMax;
      actFlip   <= progFlip;
      actGuard  <= progGuard;
      actFlipEn <= progFlipEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (strobe.cntClear) begin
      lineCnt <= '0;
    end else if (strobe.cntStep) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_comb begin
    lineNext   = {1'b0, lineCnt} + 1'b1;
    totalExt   = {1'b0, actMax} + 1'b1;
    guardEff   = (actGuard == '0) ? EXT_W'(1) : {{(EXT_W-GB_W){1'b0}}, actGuard};
    vbStart    = (guardEff >= totalExt) ? '0 : totalExt - guardEff;
    minPlusOne = {1'b0, actMin} + 1'b1;
    if (actFlipEn) begin
      earliestReg = ({1'b0, actFlip} > minPlusOne) ? {1'b0, actFlip} : minPlusOne;
    end else begin
      earliestReg = {1'b0, actMin};
    end
  end

  always_comb begin
    flags.atDeadline  = lineCnt >= actMax;
    flags.atEarliest  = {1'b0, lineCnt} >= earliestReg;
    flags.pushPending = pushSend;
    flags.hitVbsStep  = lineNext == vbStart;
    flags.geVbsStep   = lineNext >= vbStart;
    flags.vbsZero     = vbStart == '0;
    flags.ctrlEnable  = progEn;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_MIN:  rdData = progMin;
      ADDR_MAX:  rdData = progMax;
      ADDR_FLIP: rdData = progFlip;
      ADDR_CTRL: begin
        rdData[CTRL_EN_BIT]          = progEn;
        rdData[CTRL_FLIP_BIT]        = progFlipEn;
        rdData[CTRL_IGN_BIT]         = progIgn;
        rdData[CTRL_GB_LSB +: GB_W]  = progGuard;
      end
      ADDR_PUSH: begin
        rdData[PUSH_EN_BIT]   = pushEn;
        rdData[PUSH_SEND_BIT] = pushSend;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/vrr_control.sv
module vrr_control
  import vrr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineTick,
  input  vrrFlags_t  flags,
  output vrrStrobe_t strobe,
  output logic       frameStart,
  output logic       regLatch,
  output logic       vblank,
  output logic       liveEn
);
  logic exitNow, latchNow, vblankNext;

  always_comb begin
    exitNow = lineTick &&
              (flags.atDeadline || (liveEn && flags.pushPending && flags.atEarliest));
    if (liveEn) begin
      latchNow = exitNow;
    end else begin
      latchNow = lineTick && (exitNow ? flags.vbsZero : flags.hitVbsStep);
    end
    vblankNext      = exitNow ? flags.vbsZero : flags.geVbsStep;
    strobe.cntClear = exitNow;
    strobe.cntStep  = lineTick && !exitNow;
    strobe.latch    = latchNow;
    strobe.consume  = exitNow && liveEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameStart <= 1'b0;
      regLatch   <= 1'b0;
      vblank     <= 1'b0;
      liveEn     <= 1'b0;
    end else begin
      frameStart <= exitNow;
      regLatch   <= latchNow;
      if (lineTick) vblank <= vblankNext;
      if (exitNow)  liveEn <= flags.ctrlEnable;
    end
  end
endmodule

// File: rtl/vrr_timing_ctrl.sv
module vrr_timing_ctrl
  import vrr_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int GB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LINE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LINE_W-1:0] rdData,
  output logic              vblank,
  output logic              frameStart,
  output logic              regLatch,
  output logic              liveEn
);
  vrrStrobe_t        strobe;
  vrrFlags_t         flags;
  logic [LINE_W-1:0] lineCnt, actMax;
  logic              pushSend;

  vrr_datapath #(.LINE_W(LINE_W), .GB_W(GB_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strobe(strobe), .flags(flags),
    .lineCnt(lineCnt), .actMax(actMax), .pushSend(pushSend)
  );

  vrr_control uCtrl (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .flags(flags), .strobe(strobe),
    .frameStart(frameStart), .regLatch(regLatch), .vblank(vblank), .liveEn(liveEn)
  );
endmodule

// File: rtl/vrr_timing_checker.sv
module vrr_timing_checker #(
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineTick,
  input logic              wrEn,
  input logic              frameStart,
  input logic              regLatch,
  input logic              liveEn,
  input logic              pushSend,
  input logic [LINE_W-1:0] lineCnt,
  input logic [LINE_W-1:0] actMax
);
  // R4: a frame start always follows a line tick
  p_fs_after_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(lineTick));

  // R5: reaching the deadline on a tick ends the frame
  p_deadline_forces_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lineTick && lineCnt >= actMax) |=> frameStart);

  // R5: in variable mode latching happens only at the frame exit
  p_live_latch_at_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regLatch && !frameStart) |-> !liveEn);

  // R10: live enable only changes at a frame boundary
  p_live_changes_at_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveEn) |-> frameStart);

  // R9: a push is consumed only at a frame boundary
  p_push_consumed_at_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pushSend) && !$past(wrEn)) |-> frameStart);
endmodule

bind vrr_timing_ctrl vrr_timing_checker #(.LINE_W(LINE_W)) uChk (
  .clk(clk), .rstN(rstN), .lineTick(lineTick), .wrEn(wrEn),
  .frameStart(frameStart), .regLatch(regLatch), .liveEn(liveEn),
  .pushSend(pushSend), .lineCnt(lineCnt), .actMax(actMax)
);

// File: tb/tb_vrr_timing_ctrl.sv
module tb_vrr_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineTick = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [LW-1:0] wrData = '0;
  logic [2:0]    rdAddr = '0;
  logic [LW-1:0] rdData;
  logic          vblank, frameStart, regLatch, liveEn;

  int checks = 0;
  int failures = 0;

  vrr_timing_ctrl dut (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .vblank(vblank),
    .frameStart(frameStart), .regLatch(regLatch), .liveEn(liveEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [LW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rdAddr = a;
    #1 v = int'(rdData);
  endtask

  task automatic tick();
    @(negedge clk);
    lineTick = 1'b1;
    @(negedge clk);
    lineTick = 1'b0;
  endtask

  // run one frame from line 0; optional register write before tick wrAt
  task automatic measure(input int wrAt, input logic [2:0] a, input logic [LW-1:0] d,
                         output int len, output int latchAt, output int vbAt,
                         output int liveFirst);
    len = 0; latchAt = 0; vbAt = 0; liveFirst = 0;
    for (int k = 1; k <= 300; k++) begin
      if (k == wrAt) wr(a, d);
      tick();
      if (k == 1) liveFirst = int'(liveEn);
      if (regLatch && latchAt == 0) latchAt = k;
      if (vblank && vbAt == 0) vbAt = k;
      if (frameStart) begin
        len = k;
        break;
      end
    end
    if (len == 0) check("R4 frame never ended", 0, 1);
  endtask

  int len, la, vb, lf, v;

  task automatic t_reset();
    check("R4 reset frameStart", int'(frameStart), 0);
    check("R2 reset regLatch", int'(regLatch), 0);
    check("R3 reset vblank", int'(vblank), 0);
    check("R10 reset liveEn", int'(liveEn), 0);
    rd(3'd4, v);
    check("R9 reset push readback", v, 0);
  endtask

  task automatic t_setup();
    wr(3'd0, 16'd9);
    wr(3'd1, 16'd19);
    wr(3'd2, 16'd11);
    wr(3'd3, 16'h0502);
    rd(3'd0, v);
    check("R1 min readback", v, 9);
    rd(3'd3, v);
    check("R1 ctrl readback", v, 16'h0502);
    tick();
    check("R4 first tick frameStart", int'(frameStart), 1);
    check("R11 first tick latch", int'(regLatch), 1);
  endtask

  task automatic t_fixed();
    measure(-1, 3'd0, 16'd0, len, la, vb, lf);
    check("R2 fixed length", len, 20);
    check("R2 fixed latch line", la, 15);
    check("R3 fixed vblank start", vb, 15);
    check("R3 vblank low at line 0", int'(vblank), 0);
    check("R10 live low in fixed", lf, 0);
  endtask

  task automatic t_enable();
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0503);
    measure(-1, 3'd0, 16'd0, len, la, vb, lf);
    check("R10 enable frame stays fixed length", len, 20);
    check("R10 enable frame fixed latch", la, 15);
    check("R10 live during enable frame", lf, 0);
    check("R10 live after boundary", int'(liveEn), 1);
  endtask

  task automatic t_vrr_nopush();
    measure(-1, 3'd0, 16'd0, len, la, vb, lf);
    check("R5 deadline length", len, 20);
    check("R5 latch at exit", la, 20);
    check("R3 variable vblank start", vb, 15);
  endtask

  task automatic t_push_early();
    measure(1, 3'd4, 16'h0003, len, la, vb, lf);
    check("R6 early push exits at flip line", len, 12);
    check("R6 latch at exit", la, 12);
    rd(3'd4, v);
    check("R9 push consumed", v, 1);
  endtask

  task automatic t_push_late();
    measure(16, 3'd4, 16'h0003, len, la, vb, lf);
    check("R7 late push exits next tick", len, 16);
  endtask

  task automatic t_push_ignored();
    wr(3'd4, 16'h0002);
    rd(3'd4, v);
    check("R9 send without enable dropped", v, 0);
    measure(-1, 3'd0, 16'd0, len, la, vb, lf);
    check("R9 dropped push has no effect", len, 20);
    wr(3'd4, 16'h0001);
  endtask

  task automatic t_shadow();
    measure(3, 3'd1, 16'd24, len, la, vb, lf);
    check("R11 mid-frame max write ignored", len, 20);
    measure(-1, 3'd0, 16'd0, len, la, vb, lf);
    check("R11 new max in effect", len, 25);
    check("R3 new vblank start", vb, 20);
    measure(3, 3'd1, 16'd19, len, la, vb, lf);
    check("R11 restore frame length", len, 25);
  endtask

  task automatic t_flip_off();
    measure(3, 3'd3, 16'h0501, len, la, vb, lf);
    check("R11 ctrl write frame", len, 20);
    measure(1, 3'd4, 16'h0003, len, la, vb, lf);
    check("R8 flip disabled uses min total", len, 10);
  endtask

  task automatic t_flip_low();
    wr(3'd2, 16'd5);
    measure(3, 3'd3, 16'h0503, len, la, vb, lf);
    check("R8 setup frame", len, 20);
    measure(1, 3'd4, 16'h0003, len, la, vb, lf);
    check("R8 flip clamped past min", len, 11);
  endtask

  task automatic t_disable();
    wr(3'd3, 16'h0502);
    measure(1, 3'd4, 16'h0003, len, la, vb, lf);
    check("R10 live held during disable frame", lf, 1);
    check("R10 disable frame still variable", len, 11);
    check("R10 live low after boundary", int'(liveEn), 0);
  endtask

  task automatic t_fixed_push();
    measure(1, 3'd4, 16'h0003, len, la, vb, lf);
    check("R9 fixed mode ignores push", len, 20);
    check("R2 fixed latch again", la, 15);
    rd(3'd4, v);
    check("R9 push kept in fixed mode", v, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_fixed();
    t_enable();
    t_vrr_nopush();
    t_push_early();
    t_push_late();
    t_push_ignored();
    t_shadow();
    t_flip_off();
    t_flip_low();
    t_disable();
    t_fixed_push();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule